// File: doc/BRIEF.md
# Error Interrupt Controller with First-Error Capture

This block gathers five hardware error events from a buffer-management engine and holds each in a sticky status bit. Software acknowledges a bit by writing a one to it. A per-bit enable register selects which pending bits raise the single level-sensitive interrupt line. A separate inhibit register stops chosen events from latching at all. The inhibit register is independent of the enable mask: an enabled but inhibited source stays silent, while a disabled source still records its events.

A capture status register records which event classes occurred in the first error cycle. It then freezes until software writes every set bit back. This keeps the details of the first failure from being overwritten by later ones.

The register port is a plain word-wide strobe interface. A write strobe lasts one cycle, and read data appears one cycle after the read strobe. Event bit positions are the same in every event register: bit 0 pool state change, bit 1 single-bit ECC error, bit 2 multi-bit ECC error, bit 3 free-pool-memory low watermark, bit 4 invalid command verb.

Top module: `errirq_ctl`

## Requirements
- R1: After reset every register reads zero, `irq_o` is low and `rdata_o` is zero.
- R2: An event input bit high in a cycle where its inhibit bit is clear sets the status bit at the same position (0 pool change, 1 single-bit ECC, 2 multi-bit ECC, 3 low watermark, 4 invalid command). The bit then stays set until it is cleared.
- R3: A write to status offset 0xE00 clears exactly the status bits whose write-data bit is one and leaves the other status bits unchanged.
- R4: An event that arrives in the same cycle as a clear write to its own status bit wins, so the bit stays set.
- R5: The enable register (0xE04) and the inhibit register (0xE08) read back the value written to bits 4:0. An event whose inhibit bit is set never sets its status bit.
- R6: `irq_o` is high exactly when (status AND enable), as held after the previous clock edge, is non-zero. It therefore rises or falls one cycle after the status or enable change.
- R7: The capture register (0xA00) is armed while it is all zero. When armed, every event that latches into status in a cycle also sets its capture bit. While any capture bit is set, new events do not change the capture register.
- R8: A write to 0xA00 clears the capture bits whose write-data bit is one. Capture is re-armed only when no capture bit is left set.
- R9: Reads of any other offset return zero, and writes to any other offset change no register. Bits 31:5 of every register read as zero.
- R10: `rdata_o` carries the addressed register in the cycle after `rd_en_i` and is zero in every cycle not preceded by a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 5 | Error event inputs, one per class, sampled each cycle |
| wr_en_i | input | 1 | One-cycle write strobe |
| rd_en_i | input | 1 | One-cycle read strobe |
| addr_i | input | 12 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after `rd_en_i` |
| irq_o | output | 1 | Level-sensitive interrupt |

## Verification
The bench sweeps all 32 inhibit masks against all 32 event patterns. A design that treated inhibit as an output mask, or that captured inhibited events, would show stray status or capture bits. It sweeps every clear mask over a full status word, and every enable mask over every status pattern. These sweeps catch a clear that touches neighbouring bits or an interrupt that does not drop a cycle after the status is cleared. Directed cases cover an event colliding with its own clear, which a design that gives the clear priority would lose. They also cover partial re-arming of capture, which a design that re-arms on any write would get wrong. Finally, they cover writes to unmapped offsets that must not alias onto real registers.

// File: rtl/errirq_pkg.sv
package errirq_pkg;

    // Event bit positions shared by status, enable, inhibit and capture.
    typedef enum int unsigned {
        EV_POOL_CHG = 0,
        EV_ECC_1B   = 1,
        EV_ECC_MB   = 2,
        EV_LOWMARK  = 3,
        EV_BAD_CMD  = 4
    } evt_idx_e;

    // Register selected by the current access.
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_EN,
        SEL_INH,
        SEL_CAP
    } reg_sel_e;

endpackage

// File: rtl/errirq_regif.sv
module errirq_regif
    import errirq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int EVT_N  = 5,
    parameter logic [ADDR_W-1:0] OFS_STAT = 'hE00,
    parameter logic [ADDR_W-1:0] OFS_EN   = 'hE04,
    parameter logic [ADDR_W-1:0] OFS_INH  = 'hE08,
    parameter logic [ADDR_W-1:0] OFS_CAP  = 'hA00
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [EVT_N-1:0]  stat_i,
    input  logic [EVT_N-1:0]  cap_i,
    output logic [EVT_N-1:0]  en_o,
    output logic [EVT_N-1:0]  inh_o,
    output logic              stat_clr_o,
    output logic              cap_clr_o,
    output logic [EVT_N-1:0]  clr_mask_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int PAD_W = DATA_W - EVT_N;

    typedef struct packed {
        logic [EVT_N-1:0]  en;
        logic [EVT_N-1:0]  inh;
        logic [DATA_W-1:0] rdata;
    } regif_t;

    regif_t   cur_q, nxt_d;
    reg_sel_e sel;
    logic [EVT_N-1:0] rd_field;
    logic unused_wdata;

    assign unused_wdata = ^wdata_i[DATA_W-1:EVT_N];

    always_comb begin
        sel = SEL_NONE;
        if (addr_i == OFS_STAT) sel = SEL_STAT;
        else if (addr_i == OFS_EN)  sel = SEL_EN;
        else if (addr_i == OFS_INH) sel = SEL_INH;
        else if (addr_i == OFS_CAP) sel = SEL_CAP;
    end

    always_comb begin
        nxt_d = cur_q;
        rd_field = '0;
        case (sel)
            SEL_STAT: rd_field = stat_i;
            SEL_EN:   rd_field = cur_q.en;
            SEL_INH:  rd_field = cur_q.inh;
            SEL_CAP:  rd_field = cap_i;
            default:  rd_field = '0;
        endcase
        if (wr_en_i && sel == SEL_EN)  nxt_d.en  = wdata_i[EVT_N-1:0];
        if (wr_en_i && sel == SEL_INH) nxt_d.inh = wdata_i[EVT_N-1:0];
        nxt_d.rdata = rd_en_i ? {{PAD_W{1'b0}}, rd_field} : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= nxt_d;
    end

    assign en_o       = cur_q.en;
    assign inh_o      = cur_q.inh;
    assign rdata_o    = cur_q.rdata;
    assign stat_clr_o = wr_en_i && (sel == SEL_STAT);
    assign cap_clr_o  = wr_en_i && (sel == SEL_CAP);
    assign clr_mask_o = wdata_i[EVT_N-1:0];

    // R10
    idle_rdata_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> rdata_o == '0);
    // R9
    unmapped_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel == SEL_NONE) |=> rdata_o == '0);
    // R9
    upper_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdata_o[DATA_W-1:EVT_N] == '0);
    // R5
    en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && sel == SEL_EN) |=> $stable(en_o));
    // R5
    inh_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && sel == SEL_INH) |=> $stable(inh_o));

endmodule

// File: rtl/errirq_status.sv
module errirq_status #(
    parameter int EVT_N = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [EVT_N-1:0] evt_i,
    input  logic [EVT_N-1:0] inh_i,
    input  logic             clr_we_i,
    input  logic [EVT_N-1:0] clr_mask_i,
    output logic [EVT_N-1:0] evt_eff_o,
    output logic [EVT_N-1:0] stat_o
);

    typedef struct packed {
        logic [EVT_N-1:0] stat;
    } stat_t;

    stat_t cur_q, nxt_d;
    logic [EVT_N-1:0] clr;
    logic [EVT_N-1:0] evt_eff;

    always_comb begin
        nxt_d   = cur_q;
        evt_eff = evt_i & ~inh_i;
        clr     = clr_we_i ? clr_mask_i : '0;
        // a fresh event outranks a clear of the same bit
        nxt_d.stat = (cur_q.stat & ~clr) | evt_eff;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= nxt_d;
    end

    assign stat_o    = cur_q.stat;
    assign evt_eff_o = evt_eff;

    for (genvar i = 0; i < EVT_N; i++) begin : g_bit_chk
        // R5
        inhibit_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (inh_i[i] && !stat_o[i]) |=> !stat_o[i]);
        // R2
        sticky_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (stat_o[i] && !(clr_we_i && clr_mask_i[i])) |=> stat_o[i]);
        // R4
        event_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (evt_i[i] && !inh_i[i]) |=> stat_o[i]);
        // R3
        clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_we_i && clr_mask_i[i] && !evt_i[i]) |=> !stat_o[i]);
    end

endmodule

// File: rtl/errirq_capture.sv
module errirq_capture #(
    parameter int EVT_N = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [EVT_N-1:0] evt_eff_i,
    input  logic             clr_we_i,
    input  logic [EVT_N-1:0] clr_mask_i,
    output logic [EVT_N-1:0] cap_o
);

    typedef struct packed {
        logic [EVT_N-1:0] cap;
    } cap_t;

    cap_t cur_q, nxt_d;
    logic armed;
    logic [EVT_N-1:0] clr;

    always_comb begin
        nxt_d = cur_q;
        armed = (cur_q.cap == '0);
        clr   = clr_we_i ? clr_mask_i : '0;
        nxt_d.cap = (cur_q.cap & ~clr) | (armed ? evt_eff_i : '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= nxt_d;
    end

    assign cap_o = cur_q.cap;

    // R7
    frozen_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap_o != '0 && !clr_we_i) |=> $stable(cap_o));
    // R8
    rearm_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap_o != '0 && clr_we_i) |=> (cap_o & $past(clr_mask_i)) == '0);
    // R7
    armed_record_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap_o == '0) |=> cap_o == $past(evt_eff_i));

endmodule

// File: rtl/errirq_ctl.sv
module errirq_ctl #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int EVT_N  = 5,
    parameter logic [ADDR_W-1:0] OFS_STAT = 'hE00,
    parameter logic [ADDR_W-1:0] OFS_EN   = 'hE04,
    parameter logic [ADDR_W-1:0] OFS_INH  = 'hE08,
    parameter logic [ADDR_W-1:0] OFS_CAP  = 'hA00
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [EVT_N-1:0]  evt_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    typedef struct packed {
        logic irq;
    } top_t;

    top_t cur_q, nxt_d;

    logic [EVT_N-1:0] en, inh, stat, cap, evt_eff, clr_mask;
    logic             stat_clr, cap_clr;

    errirq_regif #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EVT_N(EVT_N),
        .OFS_STAT(OFS_STAT), .OFS_EN(OFS_EN),
        .OFS_INH(OFS_INH), .OFS_CAP(OFS_CAP)
    ) u_regif (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .stat_i     (stat),
        .cap_i      (cap),
        .en_o       (en),
        .inh_o      (inh),
        .stat_clr_o (stat_clr),
        .cap_clr_o  (cap_clr),
        .clr_mask_o (clr_mask),
        .rdata_o    (rdata_o)
    );

    errirq_status #(.EVT_N(EVT_N)) u_status (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .evt_i      (evt_i),
        .inh_i      (inh),
        .clr_we_i   (stat_clr),
        .clr_mask_i (clr_mask),
        .evt_eff_o  (evt_eff),
        .stat_o     (stat)
    );

    errirq_capture #(.EVT_N(EVT_N)) u_capture (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .evt_eff_i  (evt_eff),
        .clr_we_i   (cap_clr),
        .clr_mask_i (clr_mask),
        .cap_o      (cap)
    );

    always_comb begin
        nxt_d = cur_q;
        nxt_d.irq = |(stat & en);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= nxt_d;
    end

    assign irq_o = cur_q.irq;

    // R6
    irq_falls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((stat & en) == '0) |=> !irq_o);
    // R6
    irq_rises_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((stat & en) != '0) |=> irq_o);

endmodule

// File: tb/errirq_ctl_tb.sv
module errirq_ctl_tb;

    localparam logic [11:0] A_STAT = 12'hE00;
    localparam logic [11:0] A_EN   = 12'hE04;
    localparam logic [11:0] A_INH  = 12'hE08;
    localparam logic [11:0] A_CAP  = 12'hA00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  evt = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    errirq_ctl u_dut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .evt_i   (evt),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(input logic [4:0] ev);
        @(negedge clk);
        evt = ev;
        @(negedge clk);
        evt = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [4:0]  exp_cap;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 rdata", rdata, 32'h0);
        rd(A_STAT, d); chk("R1 status", d, 32'h0);
        rd(A_EN, d);   chk("R1 enable", d, 32'h0);
        rd(A_INH, d);  chk("R1 inhibit", d, 32'h0);
        rd(A_CAP, d);  chk("R1 capture", d, 32'h0);

        // R2 / R5 / R7 sweep: every inhibit mask against every event pattern
        for (int inh = 0; inh < 32; inh++) begin
            for (int ev = 0; ev < 32; ev++) begin
                wr(A_INH, 32'(inh));
                wr(A_STAT, 32'hFFFF_FFFF);
                wr(A_CAP, 32'hFFFF_FFFF);
                pulse(5'(ev));
                rd(A_STAT, d);
                chk("R2/R5 status latch", d, 32'(ev & ~inh & 31));
                rd(A_CAP, d);
                exp_cap = 5'(ev & ~inh);
                chk("R7 first capture", d, {27'b0, exp_cap});
                pulse(5'h1F);
                if (exp_cap == 5'h0) exp_cap = 5'(~inh);
                rd(A_CAP, d);
                chk("R7 frozen capture", d, {27'b0, exp_cap});
            end
        end
        wr(A_INH, 32'h0);

        // R3 every clear mask over a full status word
        for (int m = 0; m < 32; m++) begin
            pulse(5'h1F);
            wr(A_STAT, 32'hA5A5_A5A0 | 32'(m));
            rd(A_STAT, d);
            chk("R3 W1C", d, 32'(31 & ~m));
        end

        // R6 / R5 every enable mask against every status pattern
        for (int s = 0; s < 32; s++) begin
            for (int en = 0; en < 32; en++) begin
                wr(A_STAT, 32'hFFFF_FFFF);
                pulse(5'(s));
                wr(A_EN, 32'(en));
                idle(1);
                chk("R6 irq level", {31'b0, irq}, {31'b0, |(5'(s) & 5'(en))});
                if (s == en) begin
                    rd(A_EN, d);
                    chk("R5 enable readback", d, 32'(en));
                end
                wr(A_STAT, 32'h1F);
                chk("R6 irq one-cycle lag", {31'b0, irq}, {31'b0, |(5'(s) & 5'(en))});
                idle(1);
                chk("R6 irq drop", {31'b0, irq}, 32'h0);
            end
        end
        wr(A_EN, 32'h0);

        // R4 event colliding with its own clear
        wr(A_STAT, 32'hFFFF_FFFF);
        pulse(5'h18);
        @(negedge clk);
        wr_en = 1'b1; addr = A_STAT; wdata = 32'h18; evt = 5'h08;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; evt = '0;
        rd(A_STAT, d);
        chk("R4 event beats clear", d, 32'h08);

        // R8 partial and full re-arm of capture
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_CAP, 32'hFFFF_FFFF);
        pulse(5'h03);
        rd(A_CAP, d); chk("R8 captured", d, 32'h03);
        wr(A_CAP, 32'h01);
        rd(A_CAP, d); chk("R8 partial clear", d, 32'h02);
        pulse(5'h10);
        rd(A_CAP, d); chk("R8 still disarmed", d, 32'h02);
        wr(A_CAP, d);
        rd(A_CAP, d); chk("R8 cleared by write-back", d, 32'h00);
        pulse(5'h10);
        rd(A_CAP, d); chk("R8 re-armed capture", d, 32'h10);

        // R9 unmapped offsets and upper bits
        wr(A_EN, 32'h15);
        wr(A_INH, 32'h0A);
        wr(12'hE0C, 32'hFFFF_FFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        wr(12'hA04, 32'hFFFF_FFFF);
        wr(12'hE01, 32'hFFFF_FFFF);
        rd(A_EN, d);    chk("R9 enable untouched", d, 32'h15);
        rd(A_INH, d);   chk("R9 inhibit untouched", d, 32'h0A);
        rd(A_CAP, d);   chk("R9 capture untouched", d, 32'h10);
        rd(12'hE0C, d); chk("R9 unmapped read", d, 32'h0);
        rd(12'h000, d); chk("R9 unmapped read low", d, 32'h0);
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, d);    chk("R9 upper bits zero", d, 32'h1F);

        // R10 read data only in the cycle after the strobe
        rd(A_EN, d);
        chk("R10 read valid", d, 32'h1F);
        idle(1);
        chk("R10 idle zero", rdata, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule